// File: doc/BRIEF.md
# Port Expander Two-Wire Slave Sequencer

This block is the serial front end of an eight-bit open-drain port expander. It watches the two bus lines, SCL and SDA, through two-flop synchronizers clocked by a fast system clock that runs at least 16 times the SCL rate. It recognises START and STOP conditions, shifts bytes in and out MSB first, and drives SDA low through a pull-down enable whenever it acknowledges or sends a zero. The upper three bits of the device address are fixed at 1,1,0. An external address decoder supplies the low four bits.

The block has no register pointer. After it acknowledges its own address, every write data byte goes straight into the eight port output latches. A read streams two kinds of byte in turn: the live port levels, then the change flags from the transition detector. The acknowledge clock of the address, in either direction, sends a one-clock snapshot-and-clear strobe to that detector. The block also gives the detector a strobe when a STOP is seen and a level that is high while a read session is open, so that the detector can re-raise its interrupt at the end of a read. An asynchronous abort input ends any transaction and puts the interface in its idle state. It does not touch the port latches.

Top module: `xpdr_link`

## Requirements
- R1: A START (SDA falling while SCL is high) begins a new address phase from any state, including in the middle of a transaction (repeated START), and releases SDA. A STOP (SDA rising while SCL is high) returns the block to idle, releases SDA and pulses `stop_seen` for exactly one clock.
- R2: The first byte after a START is the 7-bit address, MSB first, followed by the direction bit (0 = write, 1 = read). When the address equals `{1,1,0,addr_low[3:0]}`, the block pulls SDA low for the whole ninth clock. On any other address it never pulls SDA, and it ignores all bits until the next START or STOP.
- R3: During the acknowledge clock of its own address, for both reads and writes, `snap_clr` pulses for exactly one clock. A non-matching address gives no pulse.
- R4: Each write data byte is acknowledged, and on that acknowledge all eight bits are loaded into `port_out`, with the first bit received in bit 7. Further bytes update `port_out` again until STOP. After reset `port_out` holds the parameter `RESET_PORTS` (default 8'hFF).
- R5: The first byte of a read is `port_lvl` as sampled at the address acknowledge. The second is `chg_flags` as captured in that same clock, before the clear takes effect. Both are sent MSB first.
- R6: A read that goes past two bytes keeps alternating port byte and flag byte. Each further port byte is resampled from `port_lvl` when the master acknowledges the previous flag byte. That resample gives another one-clock `snap_clr` pulse, and the flags it captures at that moment become the following flag byte.
- R7: When the master does not acknowledge a read byte, the block releases SDA and drives nothing more until the next START or STOP.
- R8: `rd_active` is high from the end of the acknowledge clock of a matching read address until the next START, STOP or abort. It is low during writes.
- R9: While `bus_abort` is high, SDA is released, the block is idle and no strobe is issued. This takes effect without waiting for a clock edge. `port_out` keeps its value, and bus bits after the abort are ignored until a START.
- R10: While `rst_n` is low, `sda_pull`, `snap_clr`, `stop_seen` and `rd_active` are 0 and `port_out` equals `RESET_PORTS`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Active-low power-on reset |
| bus_abort | input | 1 | Asynchronous, active-high transaction abort |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level (wired bus) |
| addr_low | input | 4 | Low address bits from the address decoder |
| port_lvl | input | 8 | Live levels at the eight ports |
| chg_flags | input | 8 | Change flags from the transition detector |
| sda_pull | output | 1 | SDA pull-down enable |
| port_out | output | 8 | Port output latches (1 = released) |
| snap_clr | output | 1 | Snapshot-and-clear strobe to the detector |
| stop_seen | output | 1 | One-clock strobe on STOP |
| rd_active | output | 1 | Read session in progress |

## Verification
The hardest case to reach from the ports is an abort that arrives while the block is holding SDA low for an acknowledge. The bench stops its master model just after the eighth address bit, in the low phase where the acknowledge is driven, and pulses the abort there. It then sends a full data byte with no new START and confirms that no acknowledge comes back and the port latches do not move. A second case is the flag capture on a read longer than two bytes. The bench changes the port levels and flags while the second byte is in flight, so the third and fourth bytes reveal the exact moment the resample happens.

// File: rtl/xpdr_pkg.sv
package xpdr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDAT,
    ST_WACK,
    ST_RDAT,
    ST_RACK,
    ST_SKIP
  } xp_state_t;

  localparam logic [2:0] DEV_PREFIX = 3'b110;

  // Full 7-bit device address built from the decoder bits.
  function automatic logic [6:0] dev_addr(input logic [3:0] low);
    return {DEV_PREFIX, low};
  endfunction

  // Header byte = address (7 bits) followed by direction bit.
  function automatic logic addr_hit(input logic [7:0] hdr, input logic [3:0] low);
    return hdr[7:1] == dev_addr(low);
  endfunction

endpackage

// File: rtl/xpdr_sync.sv
module xpdr_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '1;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/xpdr_cond.sv
module xpdr_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);

  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;

endmodule

// File: rtl/xpdr_seq.sv
module xpdr_seq
  import xpdr_pkg::*;
#(
  parameter int          PW          = 8,
  parameter int          AW          = 4,
  parameter logic [PW-1:0] RESET_PORTS = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_abort,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_s,
  input  logic [AW-1:0] addr_low,
  input  logic [PW-1:0] port_lvl,
  input  logic [PW-1:0] chg_flags,
  output logic          sda_pull,
  output logic [PW-1:0] port_out,
  output logic          snap_clr,
  output logic          stop_seen,
  output logic          rd_active
);

  localparam int CW = $clog2(PW + 1);
  localparam logic [CW-1:0] FULL = CW'(PW);
  localparam logic [CW-1:0] LAST = CW'(PW - 1);

  xp_state_t     st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] rx, tx, flag_hold;
  logic          rw, mack, nxt_flags;

  // Named internal events
  logic byte_in_done, addr_ok, wr_load, tx_done, rd_next, rd_stop;

  assign byte_in_done = scl_fall && (cnt == FULL);
  assign addr_ok      = addr_hit(rx, addr_low);
  assign wr_load      = (st == ST_WDAT) && byte_in_done;
  assign tx_done      = (st == ST_RDAT) && scl_fall && (cnt == LAST);
  assign rd_next      = (st == ST_RACK) && scl_fall && mack;
  assign rd_stop      = (st == ST_RACK) && scl_fall && !mack;

  always_ff @(posedge clk or negedge rst_n or posedge bus_abort) begin
    if (!rst_n || bus_abort) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      rx        <= '0;
      tx        <= '0;
      flag_hold <= '0;
      rw        <= 1'b0;
      mack      <= 1'b0;
      nxt_flags <= 1'b0;
      sda_pull  <= 1'b0;
      snap_clr  <= 1'b0;
      stop_seen <= 1'b0;
      rd_active <= 1'b0;
    end else begin
      snap_clr  <= 1'b0;
      stop_seen <= 1'b0;
      if (start_evt) begin
        st        <= ST_ADDR;
        cnt       <= '0;
        sda_pull  <= 1'b0;
        rd_active <= 1'b0;
      end else if (stop_evt) begin
        st        <= ST_IDLE;
        sda_pull  <= 1'b0;
        rd_active <= 1'b0;
        stop_seen <= 1'b1;
      end else begin
        unique case (st)
          ST_ADDR, ST_WDAT: begin
            if (scl_rise) begin
              rx  <= {rx[PW-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (byte_in_done) begin
              if (st == ST_WDAT) begin
                st       <= ST_WACK;
                sda_pull <= 1'b1;
              end else if (addr_ok) begin
                st       <= ST_AACK;
                sda_pull <= 1'b1;
                rw       <= rx[0];
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_AACK: begin
            if (scl_rise) begin
              snap_clr  <= 1'b1;
              tx        <= port_lvl;
              flag_hold <= chg_flags;
            end else if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                st        <= ST_RDAT;
                rd_active <= 1'b1;
                nxt_flags <= 1'b1;
                sda_pull  <= ~tx[PW-1];
              end else begin
                st       <= ST_WDAT;
                sda_pull <= 1'b0;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              st       <= ST_WDAT;
              cnt      <= '0;
              sda_pull <= 1'b0;
            end
          end
          ST_RDAT: begin
            if (tx_done) begin
              st       <= ST_RACK;
              sda_pull <= 1'b0;
            end else if (scl_fall) begin
              tx       <= {tx[PW-2:0], 1'b0};
              sda_pull <= ~tx[PW-2];
              cnt      <= cnt + 1'b1;
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (rd_next) begin
              st  <= ST_RDAT;
              cnt <= '0;
              if (nxt_flags) begin
                tx        <= flag_hold;
                sda_pull  <= ~flag_hold[PW-1];
                nxt_flags <= 1'b0;
              end else begin
                tx        <= port_lvl;
                flag_hold <= chg_flags;
                snap_clr  <= 1'b1;
                sda_pull  <= ~port_lvl[PW-1];
                nxt_flags <= 1'b1;
              end
            end else if (rd_stop) begin
              st       <= ST_SKIP;
              sda_pull <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Port latches survive an abort; only power-on reset restores them.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       port_out <= RESET_PORTS;
    else if (wr_load) port_out <= rx;
  end

  // ---------------- assertions ----------------
  a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n || bus_abort)
    stop_evt |=> (!sda_pull && stop_seen && !rd_active));

  a_r1_start_releases: assert property (@(posedge clk) disable iff (!rst_n || bus_abort)
    start_evt |=> (!sda_pull && !rd_active));

  a_r3_snap_one_clock: assert property (@(posedge clk) disable iff (!rst_n || bus_abort)
    snap_clr |=> !snap_clr);

  a_r3_snap_during_ack: assert property (@(posedge clk) disable iff (!rst_n || bus_abort)
    (snap_clr && !rd_active) |-> sda_pull);

  a_r4_port_moves_on_ack: assert property (@(posedge clk) disable iff (!rst_n || bus_abort)
    !$stable(port_out) |-> (sda_pull && !rd_active));

  a_r7_nack_releases: assert property (@(posedge clk) disable iff (!rst_n || bus_abort)
    rd_stop |=> !sda_pull);

  a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    bus_abort |-> (!sda_pull && !snap_clr && !rd_active && !stop_seen));

endmodule

// File: rtl/xpdr_link.sv
module xpdr_link #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] RESET_PORTS = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_abort,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [3:0] addr_low,
  input  logic [7:0] port_lvl,
  input  logic [7:0] chg_flags,
  output logic       sda_pull,
  output logic [7:0] port_out,
  output logic       snap_clr,
  output logic       stop_seen,
  output logic       rd_active
);

  logic [1:0] lines_s;
  logic start_evt, stop_evt, scl_rise, scl_fall;

  xpdr_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({scl_in, sda_in}),
    .dout (lines_s)
  );

  xpdr_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (lines_s[1]),
    .sda_s    (lines_s[0]),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  xpdr_seq #(.PW(8), .AW(4), .RESET_PORTS(RESET_PORTS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_abort(bus_abort),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_s    (lines_s[0]),
    .addr_low (addr_low),
    .port_lvl (port_lvl),
    .chg_flags(chg_flags),
    .sda_pull (sda_pull),
    .port_out (port_out),
    .snap_clr (snap_clr),
    .stop_seen(stop_seen),
    .rd_active(rd_active)
  );

endmodule

// File: tb/sim_xpdr_link.sv
module sim_xpdr_link;

  localparam int CLK_P = 10;
  localparam int Q     = 8;   // quarter SCL period in clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_abort = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [3:0] addr_low = 4'hA;
  logic [7:0] port_lvl = 8'h00, chg_flags = 8'h00;
  logic sda_pull, snap_clr, stop_seen, rd_active;
  logic [7:0] port_out;
  logic sda_line;

  int n_vec = 0, n_bad = 0;
  int snap_n = 0, stop_n = 0;
  logic [7:0] exp_q[$];
  logic [7:0] last_port = 8'hFF;

  assign sda_line = m_sda & ~sda_pull;

  always #(CLK_P/2) clk = ~clk;

  xpdr_link u0 (
    .clk(clk), .rst_n(rst_n), .bus_abort(bus_abort),
    .scl_in(m_scl), .sda_in(sda_line), .addr_low(addr_low),
    .port_lvl(port_lvl), .chg_flags(chg_flags),
    .sda_pull(sda_pull), .port_out(port_out), .snap_clr(snap_clr),
    .stop_seen(stop_seen), .rd_active(rd_active)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (snap_clr)  snap_n++;
    if (stop_seen) stop_n++;
  end

  // Monitor: every port latch change is popped from the scoreboard (R4)
  always @(negedge clk) begin
    if (rst_n && port_out !== last_port) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected port update", port_out, last_port);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(port_out == e, "R4 port latch", port_out, e);
      end
      last_port = port_out;
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = sda_line; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
    send_bit(~ack);
  endtask

  // Driver: write transaction, expected latch values pushed to scoreboard
  task automatic drv_write(input logic [7:0] data[], input bit expect_hit, input logic [7:0] hdr);
    logic ack;
    bus_start();
    wr_byte(hdr, ack);
    chk(ack == expect_hit, "R2 address ack", ack, expect_hit);
    foreach (data[i]) begin
      if (expect_hit) exp_q.push_back(data[i]);
      wr_byte(data[i], ack);
      chk(ack == expect_hit, "R4 data ack", ack, expect_hit);
    end
    bus_stop();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic ack;
    int s0, p0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(port_out == 8'hFF && !sda_pull && !snap_clr && !stop_seen && !rd_active,
        "R10 reset state", port_out, 8'hFF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3/R4 single write
    s0 = snap_n; p0 = stop_n;
    drv_write('{8'h5A}, 1'b1, 8'hD4);
    wq();
    chk(snap_n == s0 + 1, "R3 snap on write address ack", snap_n - s0, 1);
    chk(stop_n == p0 + 1, "R1 stop strobe count", stop_n - p0, 1);
    chk(port_out == 8'h5A, "R4 single write", port_out, 8'h5A);

    // R4 multibyte write
    drv_write('{8'h12, 8'h34, 8'hC0}, 1'b1, 8'hD4);
    wq();
    chk(port_out == 8'hC0, "R4 multibyte final", port_out, 8'hC0);

    // R2/R3 non-matching address: ignored, no snapshot
    s0 = snap_n;
    drv_write('{8'h00, 8'h0F}, 1'b0, 8'hD6);
    wq();
    chk(snap_n == s0, "R3 no snap on mismatch", snap_n - s0, 0);
    chk(port_out == 8'hC0, "R2 mismatch leaves ports", port_out, 8'hC0);

    // R2 decoder bits change the matched address
    addr_low = 4'h3;
    drv_write('{8'h81}, 1'b1, 8'hC6);
    wq();
    chk(port_out == 8'h81, "R2 alternate address write", port_out, 8'h81);

    // R5/R6/R7/R8 four-byte read
    port_lvl = 8'hC3; chg_flags = 8'h21; s0 = snap_n;
    bus_start();
    wr_byte(8'hC7, ack);
    chk(ack, "R2 read address ack", ack, 1);
    wq();
    chk(rd_active, "R8 read session active", rd_active, 1);
    chk(snap_n == s0 + 1, "R3 snap on read address ack", snap_n - s0, 1);
    port_lvl = 8'h11; chg_flags = 8'h44;  // after snapshot: must not show in bytes 1-2
    rd_byte(d, 1'b1);
    chk(d == 8'hC3, "R5 first byte port levels", d, 8'hC3);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      recv_bit(b); d[i] = b;
      if (i == 4) begin port_lvl = 8'h77; chg_flags = 8'h08; end
    end
    send_bit(1'b0);
    chk(d == 8'h21, "R5 second byte captured flags", d, 8'h21);
    rd_byte(d, 1'b1);
    chk(d == 8'h77, "R6 third byte resampled ports", d, 8'h77);
    chk(snap_n == s0 + 2, "R6 snap on resample", snap_n - s0, 2);
    rd_byte(d, 1'b0);
    chk(d == 8'h08, "R6 fourth byte new flags", d, 8'h08);
    wq();
    chk(!sda_pull && rd_active, "R7 released after master nack", sda_pull, 0);
    // R7 further clocks read all ones (nothing driven)
    rd_byte(d, 1'b0);
    chk(d == 8'hFF, "R7 silent after nack", d, 8'hFF);
    bus_stop();
    wq();
    chk(!rd_active, "R8 read session closed by stop", rd_active, 0);

    // R1 repeated start: write then read, no STOP between
    port_lvl = 8'h3C; chg_flags = 8'h00; s0 = snap_n; p0 = stop_n;
    bus_start();
    exp_q.push_back(8'h99);
    wr_byte(8'hC6, ack);
    wr_byte(8'h99, ack);
    chk(ack && !rd_active, "R8 low during write", rd_active, 0);
    bus_start();
    wr_byte(8'hC7, ack);
    chk(ack, "R1 repeated start readdress", ack, 1);
    rd_byte(d, 1'b0);
    chk(d == 8'h3C, "R1 read after repeated start", d, 8'h3C);
    chk(stop_n == p0, "R1 no stop strobe before stop", stop_n - p0, 0);
    bus_stop();
    wq();
    chk(snap_n == s0 + 2, "R3 snap per address", snap_n - s0, 2);

    // R9 abort while the address acknowledge is being driven
    s0 = snap_n;
    bus_start();
    for (int i = 7; i >= 0; i--) send_bit(d[i] ^ d[i] ^ ((8'hC6 >> i) & 1'b1));
    m_sda = 1'b1;
    @(negedge clk);
    chk(sda_pull, "R2 ack driven before abort", sda_pull, 1);
    bus_abort = 1'b1;
    #1;
    chk(!sda_pull && !rd_active, "R9 abort releases at once", sda_pull, 0);
    @(negedge clk); bus_abort = 1'b0;
    // finish ack clock without snapshot, then a data byte that must be ignored
    m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
    wr_byte(8'h00, ack);
    chk(!ack, "R9 bits ignored after abort", ack, 0);
    chk(port_out == 8'h99, "R9 port latches kept", port_out, 8'h99);
    chk(snap_n == s0, "R9 no snap after abort", snap_n - s0, 0);
    bus_stop();
    wq();
    drv_write('{8'h0A}, 1'b1, 8'hC6);
    wq();
    chk(port_out == 8'h0A, "R9 normal write after abort", port_out, 8'h0A);
    chk(exp_q.size() == 0, "R4 all expected updates seen", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule